// File: doc/BRIEF.md
# ADC Result Store with Output Alignment

This block sits behind an analog-to-digital converter and keeps its 10-bit conversion results in a 16-word store. Each result is turned into a 16-bit word in one of four alignments as it is written: plain integer, signed integer, plain fraction or signed fraction. The signed alignments treat the raw code as offset binary, so mid-scale reads as zero.

A 4-bit code N sets how many results make one group. After N+1 results the block raises an interrupt as a one-cycle pulse and as a sticky flag that software clears. The write position then returns to the start of the active region. The store works either as one 16-word array or as two 8-word halves. In the split arrangement the halves swap roles at every interrupt: the converter fills one half while software reads the other. A status bit tells software which half is filling. Software reads any word through an index port with one cycle of latency.

Top module: `adc_result_store`

## Requirements
- R1: With format code 00 the stored word is the raw result in bits 9..0 and zeros in bits 15..10.
- R2: With format code 01 the stored word is the raw result minus 512 as a 16-bit two's complement value: bits 15..9 all carry the inverted raw bit 9, and bits 8..0 are raw bits 8..0.
- R3: With format code 10 the stored word is the raw result in bits 15..6 and zeros in bits 5..0.
- R4: With format code 11 the stored word is (raw − 512) × 64 as 16 bits: the inverted raw bit 9 in bit 15, raw bits 8..0 in bits 14..6, and zeros in bits 5..0.
- R5: With group code N, irq_pulse is high for exactly the one cycle after every (N+1)th accepted result, counted since reset or since the previous pulse.
- R6: irq_flag is set together with irq_pulse, holds until irq_clr is high at a clock edge with no new pulse, and a pulse in the same cycle as a clear leaves the flag set.
- R7: With cfg_split at 0, results go to words 0,1,2,… in order, the next result after each interrupt goes to word 0, and half_sel stays 0.
- R8: With cfg_split at 1, half_sel at 0 means words 0..7 are filling and at 1 means words 8..15 are filling. A result goes to the filling half at an offset equal to the results accepted since the last interrupt, modulo 8. At each interrupt half_sel toggles and filling restarts at offset 0 of the other half.
- R9: rd_data shows the stored word at rd_idx one cycle after rd_idx is presented.
- R10: After a synchronous reset, irq_pulse, irq_flag and half_sel are 0 and the group count starts from zero.
- R11: A cycle with res_valid low writes no word and does not advance the group count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_data | input | 10 | Raw conversion result |
| cfg_fmt | input | 2 | Output alignment code (00, 01, 10, 11) |
| cfg_split | input | 1 | 0: one 16-word array, 1: two alternating 8-word halves |
| cfg_every | input | 4 | Group code N; interrupt after N+1 results |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| rd_idx | input | 4 | Word index to read |
| rd_data | output | 16 | Stored word at rd_idx, one cycle later |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_flag | output | 1 | Sticky interrupt flag |
| half_sel | output | 1 | Filling half in split mode (1: words 8..15 filling) |

## Verification
The hardest case to reach is split mode with a group longer than a half. Once the offset wraps inside eight words, results overwrite earlier words of the same half before the swap. The stimulus reaches it by running every alignment in both arrangements with group codes 0, 3, 7 and 15, each followed by a readback of all sixteen words. Random gaps in res_valid and random clears that land on pulse cycles are mixed in. Directed raw codes 0, 511, 512 and 1023 come first in each run, so the sign edges of each alignment are checked.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
  typedef enum logic [1:0] {
    FMT_UINT  = 2'b00,
    FMT_SINT  = 2'b01,
    FMT_UFRAC = 2'b10,
    FMT_SFRAC = 2'b11
  } rb_fmt_e;
endpackage

// File: rtl/adc_rb_formatter.sv
module adc_rb_formatter
  import adc_rb_pkg::*;
#(
  parameter int RAW_W  = 10,
  parameter int WORD_W = 16
) (
  input  logic [RAW_W-1:0]  raw,
  input  rb_fmt_e           fmt,
  output logic [WORD_W-1:0] word
);
  localparam int PAD = WORD_W - RAW_W;

  logic sgn;
  assign sgn = ~raw[RAW_W-1];

  always_comb begin
    unique case (fmt)
      FMT_UINT:  word = {{PAD{1'b0}}, raw};
      FMT_SINT:  word = {{(PAD+1){sgn}}, raw[RAW_W-2:0]};
      FMT_UFRAC: word = {raw, {PAD{1'b0}}};
      default:   word = {sgn, raw[RAW_W-2:0], {PAD{1'b0}}};
    endcase
  end

  always_comb begin
    AST_FRAC_LOW_ZERO: assert (fmt inside {FMT_UINT, FMT_SINT} || word[PAD-1:0] == '0); // R3
    AST_UINT_HIGH_ZERO: assert (fmt != FMT_UINT || word[WORD_W-1:RAW_W] == '0); // R1
  end
endmodule

// File: rtl/adc_rb_sequencer.sv
module adc_rb_sequencer #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_valid,
  input  logic          cfg_split,
  input  logic [AW-1:0] cfg_every,
  input  logic          irq_clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          irq_pulse,
  output logic          irq_flag,
  output logic          half_sel
);
  logic [AW-1:0] cnt;
  logic          group_done;

  assign group_done = res_valid && (cnt == cfg_every);
  assign wr_en      = res_valid;

  generate
    if (AW > 1) begin : g_addr
      assign wr_addr = cfg_split ? {half_sel, cnt[AW-2:0]} : cnt;
    end else begin : g_addr_min
      assign wr_addr = cfg_split ? half_sel : cnt;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      irq_pulse <= 1'b0;
      irq_flag  <= 1'b0;
      half_sel  <= 1'b0;
    end else begin
      irq_pulse <= group_done;
      if (group_done)        cnt <= '0;
      else if (res_valid)    cnt <= cnt + 1'b1;
      if (group_done)        irq_flag <= 1'b1;
      else if (irq_clr)      irq_flag <= 1'b0;
      if (!cfg_split)        half_sel <= 1'b0;
      else if (group_done)   half_sel <= ~half_sel;
    end
  end

  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> irq_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag); // R6
  AST_PULSE_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(res_valid)); // R5
  AST_SINGLE_STATUS_LOW: assert property (@(posedge clk) disable iff (rst)
    !cfg_split |=> !half_sel); // R7
  AST_SPLIT_SWAP: assert property (@(posedge clk) disable iff (rst)
    (irq_pulse && $past(cfg_split)) |-> (half_sel != $past(half_sel))); // R8
endmodule

// File: rtl/adc_rb_ram.sv
module adc_rb_ram #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
  import adc_rb_pkg::*;
#(
  parameter int RAW_W  = 10,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [RAW_W-1:0]  res_data,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_split,
  input  logic [AW-1:0]     cfg_every,
  input  logic              irq_clr,
  input  logic [AW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_pulse,
  output logic              irq_flag,
  output logic              half_sel
);
  logic [WORD_W-1:0] fmt_word;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;

  adc_rb_formatter #(.RAW_W(RAW_W), .WORD_W(WORD_W)) u_fmt (
    .raw  (res_data),
    .fmt  (rb_fmt_e'(cfg_fmt)),
    .word (fmt_word)
  );

  adc_rb_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .res_valid (res_valid),
    .cfg_split (cfg_split),
    .cfg_every (cfg_every),
    .irq_clr   (irq_clr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .irq_pulse (irq_pulse),
    .irq_flag  (irq_flag),
    .half_sel  (half_sel)
  );

  adc_rb_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (fmt_word),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> !irq_pulse); // R11
endmodule

// File: tb/adc_result_store_test.sv
module adc_result_store_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, res_valid, cfg_split, irq_clr;
  logic [9:0] res_data;
  logic [1:0] cfg_fmt;
  logic [3:0] cfg_every, rd_idx;
  logic [15:0] rd_data;
  logic irq_pulse, irq_flag, half_sel;

  adc_result_store uut (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .cfg_fmt(cfg_fmt), .cfg_split(cfg_split), .cfg_every(cfg_every),
    .irq_clr(irq_clr), .rd_idx(rd_idx), .rd_data(rd_data),
    .irq_pulse(irq_pulse), .irq_flag(irq_flag), .half_sel(half_sel)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] mdl [16];
  bit  wr [16];
  int  cnt;
  bit  mhalf, mpulse, mflag;

  function automatic logic [15:0] fmtv(int f, logic [9:0] r);
    int s;
    s = int'(r) - 512;
    case (f)
      0: return {6'd0, r};
      1: return s[15:0];
      2: return {r, 6'd0};
      default: begin s = s * 64; return s[15:0]; end
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; res_valid = 0; irq_clr = 0; res_data = '0; rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    cnt = 0; mhalf = 0; mpulse = 0; mflag = 0;
    for (int i = 0; i < 16; i++) wr[i] = 0;
    chk(irq_pulse == 0, "R10 pulse", irq_pulse, 0);
    chk(irq_flag == 0, "R10 flag", irq_flag, 0);
    chk(half_sel == 0, "R10 half", half_sel, 0);
  endtask

  task automatic cyc(bit v, logic [9:0] r, bit c);
    int a;
    res_valid = v; res_data = r; irq_clr = c;
    @(posedge clk);
    if (v) begin
      a = cfg_split ? (int'(mhalf) * 8 + (cnt % 8)) : cnt;
      mdl[a] = fmtv(cfg_fmt, r); wr[a] = 1;
      if (cnt == int'(cfg_every)) begin
        mpulse = 1; cnt = 0;
        if (cfg_split) mhalf = ~mhalf;
      end else begin
        mpulse = 0; cnt++;
      end
    end else mpulse = 0;
    if (!cfg_split) mhalf = 0;
    if (mpulse) mflag = 1; else if (c) mflag = 0;
    @(negedge clk);
    chk(irq_pulse == mpulse, v ? "R5 pulse" : "R11 idle pulse", irq_pulse, mpulse);
    chk(irq_flag == mflag, "R6 flag", irq_flag, mflag);
    chk(half_sel == mhalf, cfg_split ? "R8 half" : "R7 half", half_sel, mhalf);
    res_valid = 0; irq_clr = 0;
  endtask

  task automatic rd(int i);
    string tg;
    case (cfg_fmt)
      2'd0: tg = "R1 R9 word";
      2'd1: tg = "R2 R9 word";
      2'd2: tg = "R3 R9 word";
      default: tg = "R4 R9 word";
    endcase
    rd_idx = i[3:0];
    @(posedge clk);
    @(negedge clk);
    if (wr[i]) chk(rd_data == mdl[i], tg, rd_data, mdl[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ev [4] = '{0, 3, 7, 15};
    void'($urandom(32'd4242));
    cfg_fmt = 0; cfg_split = 0; cfg_every = 0;
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 4; e++) begin
          cfg_fmt = f[1:0]; cfg_split = s[0]; cfg_every = ev[e][3:0];
          do_reset();
          cyc(1, 10'h000, 0);
          cyc(1, 10'h3FF, 0);
          cyc(1, 10'h200, 1);
          cyc(1, 10'h1FF, 0);
          for (int k = 0; k < 36; k++)
            cyc(($urandom % 10) < 6, 10'($urandom), ($urandom % 8) == 0);
          for (int i = 0; i < 16; i++) rd(i);
        end
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule